// File: doc/BRIEF.md
# Four-Beat Burst Offset Sequencer

This block produces the low offset bits of a burst address. When an access opens, it captures a starting offset and an ordering choice. Each later cycle with the step strobe active then moves it one beat along the chosen order. The offset is two bits wide by default, so one burst spans four beats. The count wraps, so the burst can start at any offset and always comes back to that offset after four steps.

Two orderings are available. The first is a plain wrapping increment from the start. The second is the exclusive-OR pattern that some processor cache-line fills expect. It is built as the start value XOR a beat count. The enclosing memory controller supplies the upper address bits. It also supplies the read and write direction, which the sequencer ignores: bursts in either direction step the same way. The block has no streamed data, so every pin is a plain control or status level and the block has no handshake.

Top module: `burst_addr_gen`

## Requirements
- R1: While reset is held and in the first cycle after its release, `addr_lo` reads 0.
- R2: A cycle with `load` high makes `addr_lo` equal that cycle's `start` on the following cycle.
- R3: When `load` and `step_n` are both asserted in one cycle, the load wins and the beat count restarts at zero.
- R4: A cycle with `load` low and `step_n` low (active-low step) moves `addr_lo` one beat along the captured order.
- R5: A cycle with `load` low and `step_n` high leaves `addr_lo` unchanged.
- R6: With `seq_sel` = 0 captured (linear), `addr_lo` equals start plus beats taken, modulo 4. For example, start 01 gives 01, 10, 11, 00.
- R7: With `seq_sel` = 1 captured (interleaved), `addr_lo` equals start XOR beats taken. For example, start 01 gives 01, 00, 11, 10, and start 10 gives 10, 11, 00, 01.
- R8: After four steps in either order, `addr_lo` is back at the start value, and further steps repeat the pattern.
- R9: `seq_sel` is sampled only in a `load` cycle. Changing it during a burst does not change the order in use.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load | input | 1 | Opens a burst: captures `start` and `seq_sel` |
| start | input | OFS_W | Starting offset of the burst |
| step_n | input | 1 | Active-low advance by one beat |
| seq_sel | input | 1 | Order select: 0 linear, 1 interleaved |
| addr_lo | output | OFS_W | Current burst offset |

## Verification
The bench targets start offsets other than zero. At those offsets the two orders split, so a design that always added would give 01, 10 instead of 01, 00 in interleaved mode. It also fires load and step together. A design with the wrong priority would come out one beat past the new start. It toggles `seq_sel` in the middle of a burst, which would switch the order of a design that reads the pin live. Long runs of steps past the fourth beat expose a counter that saturates instead of wrapping, and held cycles catch a design that creeps forward.

// File: rtl/burst_pkg.sv
package burst_pkg;
  typedef enum logic {
    ORD_LINEAR = 1'b0,
    ORD_XOR    = 1'b1
  } order_e;
endpackage

// File: rtl/burst_ctx_reg.sv
module burst_ctx_reg
  import burst_pkg::*;
#(
  parameter int OFS_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [OFS_W-1:0] start,
  input  logic             seq_sel,
  output logic [OFS_W-1:0] base_q,
  output order_e           order_q
);
  // Burst context: captured once per burst, frozen until the next load.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q  <= '0;
      order_q <= ORD_LINEAR;
    end else if (load) begin
      base_q  <= start;
      order_q <= order_e'(seq_sel);
    end
  end

  // R9: the order cannot move without a load
  assert_order_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> order_q == $past(order_q));
endmodule

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr #(
  parameter int OFS_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             step_n,
  output logic [OFS_W-1:0] beat_q
);
  localparam logic [OFS_W-1:0] ONE = OFS_W'(1);

  // Beats taken since the load; wraps naturally at 2**OFS_W.
  always_ff @(posedge clk) begin
    if (!rst_n)       beat_q <= '0;
    else if (load)    beat_q <= '0;
    else if (!step_n) beat_q <= beat_q + ONE;
  end

  // R3: a load cycle restarts the count even if a step is requested
  assert_load_restarts_R3: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> beat_q == '0);
endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
  import burst_pkg::*;
#(
  parameter int OFS_W = 2
) (
  input  logic [OFS_W-1:0] base,
  input  logic [OFS_W-1:0] beat,
  input  order_e           order,
  output logic [OFS_W-1:0] offset
);
  logic [OFS_W-1:0] lin_ofs;
  logic [OFS_W-1:0] xor_ofs;

  assign lin_ofs = base + beat;

  for (genvar b = 0; b < OFS_W; b++) begin : g_xor_bit
    assign xor_ofs[b] = base[b] ^ beat[b];
  end

  always_comb begin
    unique case (order)
      ORD_XOR: offset = xor_ofs;
      default: offset = lin_ofs;
    endcase
  end
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_pkg::*;
#(
  parameter int OFS_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [OFS_W-1:0] start,
  input  logic             step_n,
  input  logic             seq_sel,
  output logic [OFS_W-1:0] addr_lo
);
  localparam logic [OFS_W-1:0] ONE = OFS_W'(1);

  logic [OFS_W-1:0] base_q;
  logic [OFS_W-1:0] beat_q;
  order_e           order_q;

  burst_ctx_reg #(.OFS_W(OFS_W)) u_ctx (
    .clk(clk), .rst_n(rst_n), .load(load), .start(start),
    .seq_sel(seq_sel), .base_q(base_q), .order_q(order_q)
  );

  burst_beat_ctr #(.OFS_W(OFS_W)) u_beat (
    .clk(clk), .rst_n(rst_n), .load(load), .step_n(step_n), .beat_q(beat_q)
  );

  burst_order_map #(.OFS_W(OFS_W)) u_map (
    .base(base_q), .beat(beat_q), .order(order_q), .offset(addr_lo)
  );

  assert_load_takes_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> addr_lo == $past(start));

  assert_hold_when_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !load && step_n |=> $stable(addr_lo));

  assert_step_moves_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !load && !step_n |=> addr_lo != $past(addr_lo));

  assert_linear_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !load && !step_n && order_q == ORD_LINEAR |=> addr_lo == $past(addr_lo) + ONE);

  assert_xor_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !load && !step_n && order_q == ORD_XOR |=>
      (addr_lo ^ $past(addr_lo)) == ($past(beat_q) ^ ($past(beat_q) + ONE)));
endmodule

// File: tb/tb_burst_addr_gen.sv
module tb_burst_addr_gen;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       load;
  logic [1:0] start;
  logic       step_n;
  logic       seq_sel;
  logic [1:0] addr_lo;

  int checks = 0;
  int errors = 0;

  // behavioural model state
  int m_start = 0;
  int m_beat  = 0;
  int m_xor   = 0;

  always #2.5 clk = ~clk;

  burst_addr_gen dut (
    .clk(clk), .rst_n(rst_n), .load(load), .start(start),
    .step_n(step_n), .seq_sel(seq_sel), .addr_lo(addr_lo)
  );

  function automatic int model_out();
    if (m_xor != 0) return m_start ^ (m_beat % 4);
    return (m_start + m_beat) % 4;
  endfunction

  task automatic check(input int exp, input string tag);
    checks++;
    if (int'(addr_lo) != exp) begin
      errors++;
      $display("FAIL %s: addr_lo=%0d expected=%0d", tag, addr_lo, exp);
    end
  endtask

  // Drive one cycle at a negedge, advance the model at the posedge,
  // compare at the following negedge.
  task automatic cyc(input bit ld, input int st, input bit stp_n, input bit sel,
                     input string tag);
    load = ld; start = 2'(st); step_n = stp_n; seq_sel = sel;
    @(posedge clk);
    if (!rst_n) begin
      m_start = 0; m_beat = 0; m_xor = 0;
    end else if (ld) begin
      m_start = st; m_beat = 0; m_xor = sel;
    end else if (!stp_n) begin
      m_beat = m_beat + 1;
    end
    @(negedge clk);
    check(model_out(), tag);
  endtask

  initial begin
    rst_n = 1'b0; load = 1'b0; start = 2'd3; step_n = 1'b0; seq_sel = 1'b1;
    repeat (3) @(negedge clk);
    check(0, "R1 in reset");
    rst_n = 1'b1;
    cyc(0, 0, 1, 0, "R1 after release");

    // Linear order from every start, with wrap (R6, R8)
    for (int s = 0; s < 4; s++) begin
      cyc(1, s, 1, 0, "R2 load linear");
      for (int k = 0; k < 6; k++) cyc(0, 0, 0, 0, "R6 linear step");
      cyc(0, 0, 0, 0, "R8 linear wrap");
    end

    // Interleaved order from every start (R7, R8)
    for (int s = 0; s < 4; s++) begin
      cyc(1, s, 1, 1, "R2 load interleaved");
      for (int k = 0; k < 7; k++) cyc(0, 0, 0, 1, "R7 xor step");
    end

    // Literal sequences from the requirements
    cyc(1, 1, 1, 1, "R7 load 01");
    cyc(0, 0, 0, 1, "R7 seq"); check(0, "R7 literal 01->00");
    cyc(0, 0, 0, 1, "R7 seq"); check(3, "R7 literal ->11");
    cyc(0, 0, 0, 1, "R7 seq"); check(2, "R7 literal ->10");
    cyc(0, 0, 0, 1, "R8 seq"); check(1, "R8 literal back to 01");
    cyc(1, 1, 1, 0, "R6 load 01");
    cyc(0, 0, 0, 0, "R6 seq"); check(2, "R6 literal 01->10");
    cyc(0, 0, 0, 0, "R6 seq"); check(3, "R6 literal ->11");
    cyc(0, 0, 0, 0, "R6 seq"); check(0, "R6 literal ->00");

    // Holding (R5)
    cyc(1, 2, 1, 1, "R2 load 10");
    cyc(0, 0, 0, 1, "R7 step");
    for (int k = 0; k < 3; k++) cyc(0, 3, 1, 0, "R5 hold");
    check(3, "R5 literal held at 11");

    // Load beats step (R3)
    cyc(0, 0, 0, 1, "R4 step");
    cyc(1, 3, 0, 0, "R3 load with step");
    check(3, "R3 literal start taken");
    cyc(0, 0, 0, 0, "R4 step after load");
    check(0, "R3 literal 11->00 linear");

    // seq_sel toggled mid burst (R9)
    cyc(1, 1, 1, 1, "R2 load");
    cyc(0, 0, 0, 0, "R9 sel flipped");
    check(0, "R9 literal stays interleaved");
    cyc(0, 0, 0, 0, "R9 sel flipped");
    cyc(0, 0, 0, 1, "R9 sel back");
    cyc(1, 1, 1, 0, "R2 load");
    cyc(0, 0, 0, 1, "R9 sel flipped");
    check(2, "R9 literal stays linear");

    // mixed random-ish pattern
    for (int k = 0; k < 200; k++)
      cyc((k % 7) == 0, (k * 3) % 4, (k % 3) == 1, (k % 5) < 2, "R4 mixed");

    // reset mid burst
    rst_n = 1'b0;
    cyc(0, 0, 0, 1, "R1 reset mid burst");
    rst_n = 1'b1;
    cyc(0, 0, 1, 0, "R1 idle after reset");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #20000;
    errors++;
    checks++;
    $display("FAIL watchdog: expired, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule